// File: doc/BRIEF.md
# SCSI Bus Interface Register Block

This block is the byte-wide register file that a host uses to run a parallel SCSI bus by hand. A simple synchronous host port exposes eight addresses. Most addresses mean one thing when written and another when read. The host writes line-command, phase-command and mode registers. Their bits assert individual SCSI control lines and put an output byte on the data lines. Reads return the live, synchronized state of every bus line, a latched input byte and flags from the arbitration sequencer. Writes to the upper addresses produce one-cycle strobes for a separate transfer engine.

Each SCSI line appears as an "assert" output and a sampled input, both active high. The board's open-collector wired-OR is therefore modeled as the OR of every device's assert outputs. All sampled inputs pass through a synchronizer before the registers and the sequencer see them. When the mode register's arbitrate bit is set, a small sequencer waits for a bus-free window of a parameterized length. It then asserts BSY and the device's own ID bit, and it backs off when a higher ID appears on the bus while SEL is active.

Top module: `scsi_bus_regs`

## Requirements
- R1: After reset, line-command, mode and phase-command reads (addresses 1, 2, 3) return 0, no SCSI line is asserted and the select-enable output is 0.
- R2: A write to address 5, 6 or 7 raises `start_send`, `start_tgt_rx` or `start_ini_rx` respectively for that access cycle. A read of address 7 raises `irq_clear` and returns 0.
- R3: Line-command write (address 1) bits: 7 asserts RST, 4 asserts ACK, 3 asserts BSY, 2 asserts SEL, 1 asserts ATN, 0 enables data drive. ACK and ATN are asserted only in initiator mode (mode bit 6 clear). The read returns bits 7 and 4..0 as written, bit 6 as arbitration-in-progress and bit 5 as arbitration-lost. The control vector index order is ATN 0, ACK 1, BSY 2, SEL 3, RST 4, I/O 5, C/D 6, MSG 7, REQ 8.
- R4: With line-command bit 0 set and no arbitration win, the output data byte (written at address 0) is asserted on the data lines exactly when phase-command bits 2..0 equal the synchronized bus {MSG, C/D, I/O}. Otherwise no data bit is asserted. Phase codes are data-out 000, data-in 001, command 010, status 011, message-out 110 and message-in 111.
- R5: In target mode (mode bit 6 set), phase-command bits 3..0 assert REQ, MSG, C/D and I/O. In initiator mode those lines are not asserted. Reading address 3 returns `last_byte_in` in bit 7, 0 in bits 6..4 and the stored bits 3..0.
- R6: Address 4 reads synchronized {RST, BSY, REQ, MSG, C/D, I/O, SEL, parity} from bit 7 down to bit 0. A bus change becomes visible after two clock edges and not after one. Address 0 reads the synchronized data lines.
- R7: Address 5 reads {end-of-transfer, DMA request, parity error, interrupt, phase match, busy error, ATN, ACK} from bit 7 down to bit 0. The first four and busy error come from the inputs of the same meaning, and phase match is the R4 comparison.
- R8: Line-command bit 6 set on write releases every control and data line, including the arbitration drive.
- R9: The mode register (address 2) reads back all 8 bits, and bit 0 starts arbitration. Once the bit is set, the synchronized bus must show BSY and SEL both inactive for FREE_CYC consecutive cycles. The block then asserts BSY plus the output data byte ORed with its own ID bit, and sets arbitration-in-progress. With FREE_CYC=6 this happens more than FREE_CYC and at most FREE_CYC+2 edges after the write edge.
- R10: A cycle with BSY or SEL active during the bus-free wait restarts the count, so arbitration does not start while the bus stays busy.
- R11: While arbitration is in progress, a synchronized data bit above the own ID together with SEL sets arbitration-lost, clears in-progress and releases the arbitration drive. A lower ID bit has no such effect.
- R12: Clearing mode bit 0 returns the sequencer to idle with both arbitration flags clear.
- R13: Address 6 returns the synchronized data byte captured when synchronized REQ falls (initiator mode) or synchronized ACK falls (target mode). The byte holds until the next such edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 3 | Register address |
| host_wr | input | 1 | Write enable, taken at the clock edge |
| host_rd | input | 1 | Read access indicator |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data for host_addr |
| scsi_data_in | input | 8 | Sampled data lines, 1 = active |
| scsi_par_in | input | 1 | Sampled data parity line |
| scsi_ctl_in | input | 9 | Sampled control lines, index order per R3 |
| scsi_data_assert | output | 8 | Data lines this device asserts |
| scsi_ctl_assert | output | 9 | Control lines this device asserts |
| dma_end_in | input | 1 | End-of-transfer flag from the transfer engine |
| dma_req_in | input | 1 | DMA request flag |
| par_err_in | input | 1 | Parity error flag |
| irq_in | input | 1 | Interrupt line state |
| busy_err_in | input | 1 | Busy-loss error flag |
| last_byte_in | input | 1 | Last-byte-sent flag |
| sel_enable | output | 8 | Select-enable byte written at address 4 |
| start_send | output | 1 | Strobe: write to address 5 |
| start_tgt_rx | output | 1 | Strobe: write to address 6 |
| start_ini_rx | output | 1 | Strobe: write to address 7 |
| irq_clear | output | 1 | Strobe: read of address 7 |

## Verification
The bench sweeps all 256 line-command bytes in both initiator and target mode. This separates correct bit-to-line mapping and mode gating from a swapped or ungated bit, and checks that the tri-state bit overrides every drive. It crosses all 16 phase-command values with all 8 external bus phases, which catches any wrong phase comparison or data gating. It also sweeps all 256 status patterns and 32 transfer-flag patterns, which catches misordered status bits. For arbitration it runs a free bus with an exact start window, a bus held busy, and contenders with lower and higher IDs, which tells the lost rule, the free-window count and the release-on-clear apart.

// File: rtl/scsi_bus_regs_pkg.sv
package scsi_bus_regs_pkg;

   localparam int BYTE_W = 8;
   localparam int CTL_N  = 9;

   localparam int CTL_ATN = 0;
   localparam int CTL_ACK = 1;
   localparam int CTL_BSY = 2;
   localparam int CTL_SEL = 3;
   localparam int CTL_RST = 4;
   localparam int CTL_IO  = 5;
   localparam int CTL_CD  = 6;
   localparam int CTL_MSG = 7;
   localparam int CTL_REQ = 8;

   localparam logic [2:0] ADR_DATA  = 3'd0;
   localparam logic [2:0] ADR_LINE  = 3'd1;
   localparam logic [2:0] ADR_MODE  = 3'd2;
   localparam logic [2:0] ADR_PHASE = 3'd3;
   localparam logic [2:0] ADR_STAT  = 3'd4;
   localparam logic [2:0] ADR_XSTAT = 3'd5;
   localparam logic [2:0] ADR_INLAT = 3'd6;
   localparam logic [2:0] ADR_CLR   = 3'd7;

   typedef enum logic [2:0] {
      PH_DATA_OUT = 3'b000,
      PH_DATA_IN  = 3'b001,
      PH_COMMAND  = 3'b010,
      PH_STATUS   = 3'b011,
      PH_MSG_OUT  = 3'b110,
      PH_MSG_IN   = 3'b111
   } bus_phase_t;

   typedef enum logic [1:0] {
      ARB_IDLE,
      ARB_WAIT,
      ARB_WON,
      ARB_LOST
   } arb_state_t;

   typedef struct packed {
      logic rst;
      logic hiz;
      logic ack;
      logic bsy;
      logic sel;
      logic atn;
      logic dat;
   } line_cmd_t;

   typedef struct packed {
      logic blk;
      logic tgt;
      logic pchk;
      logic pint;
      logic eopint;
      logic monbsy;
      logic dma;
      logic arb;
   } mode_t;

endpackage

// File: rtl/scsi_in_sync.sv
module scsi_in_sync #(
   parameter int W      = 18,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("scsi_in_sync: STAGES must be at least 2");
   end

   logic [W-1:0] stage [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            stage[s] <= '0;
         end else begin
            if (s == 0) begin
               stage[s] <= d;
            end else begin
               stage[s] <= stage[(s == 0) ? 0 : s - 1];
            end
         end
      end
   end

   assign q = stage[STAGES-1];

endmodule

// File: rtl/scsi_arbiter.sv
module scsi_arbiter
   import scsi_bus_regs_pkg::*;
#(
   parameter int OWN_ID   = 7,
   parameter int FREE_CYC = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              arb_req,
   input  logic              bus_bsy,
   input  logic              bus_sel,
   input  logic [BYTE_W-1:0] bus_data,
   output logic              arb_drive,
   output logic              in_prog,
   output logic              lost
);

   localparam int CNT_W = (FREE_CYC < 2) ? 1 : $clog2(FREE_CYC);
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(FREE_CYC - 1);

   if (FREE_CYC < 2) begin : g_bad_free
      $error("scsi_arbiter: FREE_CYC must be at least 2");
   end
   if (OWN_ID < 0 || OWN_ID >= BYTE_W) begin : g_bad_id
      $error("scsi_arbiter: OWN_ID outside the data bus");
   end

   logic [BYTE_W-1:0] hi_mask;
   for (genvar i = 0; i < BYTE_W; i++) begin : g_mask
      assign hi_mask[i] = (i > OWN_ID);
   end

   arb_state_t       state;
   logic [CNT_W-1:0] free_cnt;
   logic             bus_free;
   logic             higher_seen;

   assign bus_free    = !bus_bsy && !bus_sel;
   assign higher_seen = bus_sel && ((bus_data & hi_mask) != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ARB_IDLE;
         free_cnt <= '0;
      end else if (!arb_req) begin
         state    <= ARB_IDLE;
         free_cnt <= '0;
      end else begin
         case (state)
            ARB_IDLE: begin
               state    <= ARB_WAIT;
               free_cnt <= '0;
            end
            ARB_WAIT: begin
               if (!bus_free) begin
                  free_cnt <= '0;
               end else if (free_cnt == CNT_LAST) begin
                  state <= ARB_WON;
               end else begin
                  free_cnt <= free_cnt + 1'b1;
               end
            end
            ARB_WON: begin
               if (higher_seen) begin
                  state <= ARB_LOST;
               end
            end
            default: state <= ARB_LOST;
         endcase
      end
   end

   assign arb_drive = (state == ARB_WON);
   assign in_prog   = (state == ARB_WON);
   assign lost      = (state == ARB_LOST);

endmodule

// File: rtl/scsi_host_regs.sv
module scsi_host_regs
   import scsi_bus_regs_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        addr,
   input  logic              wr,
   input  logic              rd,
   input  logic [BYTE_W-1:0] wdata,
   output logic [BYTE_W-1:0] rdata,
   input  logic [CTL_N-1:0]  bus_ctl,
   input  logic [BYTE_W-1:0] bus_data,
   input  logic              bus_par,
   input  logic              phase_match,
   input  logic              arb_in_prog,
   input  logic              arb_lost,
   input  logic              dma_end,
   input  logic              dma_req,
   input  logic              par_err,
   input  logic              irq,
   input  logic              busy_err,
   input  logic              last_byte,
   output logic [BYTE_W-1:0] out_byte,
   output line_cmd_t         line_cmd,
   output logic [3:0]        phase_cmd,
   output logic              mode_tgt,
   output logic              mode_arb,
   output logic [BYTE_W-1:0] sel_en,
   output logic              stb_send,
   output logic              stb_tgt_rx,
   output logic              stb_ini_rx,
   output logic              stb_irq_clr
);

   mode_t             mode;
   logic [BYTE_W-1:0] in_latch;
   logic              edge_prev;
   logic              edge_now;

   assign edge_now = mode.tgt ? bus_ctl[CTL_ACK] : bus_ctl[CTL_REQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_byte  <= '0;
         line_cmd  <= '0;
         mode      <= '0;
         phase_cmd <= '0;
         sel_en    <= '0;
         in_latch  <= '0;
         edge_prev <= 1'b0;
      end else begin
         edge_prev <= edge_now;
         if (edge_prev && !edge_now) begin
            in_latch <= bus_data;
         end
         if (wr) begin
            case (addr)
               ADR_DATA:  out_byte <= wdata;
               ADR_LINE:  line_cmd <= '{rst: wdata[7], hiz: wdata[6], ack: wdata[4],
                                        bsy: wdata[3], sel: wdata[2], atn: wdata[1],
                                        dat: wdata[0]};
               ADR_MODE:  mode <= mode_t'(wdata);
               ADR_PHASE: phase_cmd <= wdata[3:0];
               ADR_STAT:  sel_en <= wdata;
               default:   ;
            endcase
         end
      end
   end

   always_comb begin
      case (addr)
         ADR_DATA:  rdata = bus_data;
         ADR_LINE:  rdata = {line_cmd.rst, arb_in_prog, arb_lost, line_cmd.ack,
                             line_cmd.bsy, line_cmd.sel, line_cmd.atn, line_cmd.dat};
         ADR_MODE:  rdata = mode;
         ADR_PHASE: rdata = {last_byte, 3'b000, phase_cmd};
         ADR_STAT:  rdata = {bus_ctl[CTL_RST], bus_ctl[CTL_BSY], bus_ctl[CTL_REQ],
                             bus_ctl[CTL_MSG], bus_ctl[CTL_CD], bus_ctl[CTL_IO],
                             bus_ctl[CTL_SEL], bus_par};
         ADR_XSTAT: rdata = {dma_end, dma_req, par_err, irq, phase_match, busy_err,
                             bus_ctl[CTL_ATN], bus_ctl[CTL_ACK]};
         ADR_INLAT: rdata = in_latch;
         default:   rdata = '0;
      endcase
   end

   assign mode_tgt    = mode.tgt;
   assign mode_arb    = mode.arb;
   assign stb_send    = wr && (addr == ADR_XSTAT);
   assign stb_tgt_rx  = wr && (addr == ADR_INLAT);
   assign stb_ini_rx  = wr && (addr == ADR_CLR);
   assign stb_irq_clr = rd && (addr == ADR_CLR);

endmodule

// File: rtl/scsi_bus_regs.sv
module scsi_bus_regs
   import scsi_bus_regs_pkg::*;
#(
   parameter int OWN_ID      = 7,
   parameter int FREE_CYC    = 40,
   parameter int SYNC_STAGES = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [2:0]  host_addr,
   input  logic        host_wr,
   input  logic        host_rd,
   input  logic [7:0]  host_wdata,
   output logic [7:0]  host_rdata,
   input  logic [7:0]  scsi_data_in,
   input  logic        scsi_par_in,
   input  logic [8:0]  scsi_ctl_in,
   output logic [7:0]  scsi_data_assert,
   output logic [8:0]  scsi_ctl_assert,
   input  logic        dma_end_in,
   input  logic        dma_req_in,
   input  logic        par_err_in,
   input  logic        irq_in,
   input  logic        busy_err_in,
   input  logic        last_byte_in,
   output logic [7:0]  sel_enable,
   output logic        start_send,
   output logic        start_tgt_rx,
   output logic        start_ini_rx,
   output logic        irq_clear
);

   localparam int SYNC_W = CTL_N + BYTE_W + 1;
   localparam logic [BYTE_W-1:0] ID_BIT = BYTE_W'(1) << OWN_ID;

   logic [SYNC_W-1:0] sync_q;
   logic [CTL_N-1:0]  bus_ctl;
   logic [BYTE_W-1:0] bus_data;
   logic              bus_par;
   logic              arb_drive;
   logic              arb_in_prog;
   logic              arb_lost;
   logic              mode_tgt;
   logic              mode_arb;
   logic              phase_match;
   logic              line_hiz;
   logic [BYTE_W-1:0] out_byte;
   logic [3:0]        phase_cmd;
   line_cmd_t         line_cmd;

   scsi_in_sync #(.W(SYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({scsi_par_in, scsi_data_in, scsi_ctl_in}),
      .q     (sync_q)
   );

   assign bus_ctl  = sync_q[CTL_N-1:0];
   assign bus_data = sync_q[CTL_N +: BYTE_W];
   assign bus_par  = sync_q[SYNC_W-1];

   assign phase_match = (phase_cmd[2:0] ==
                         {bus_ctl[CTL_MSG], bus_ctl[CTL_CD], bus_ctl[CTL_IO]});

   scsi_arbiter #(.OWN_ID(OWN_ID), .FREE_CYC(FREE_CYC)) u_arb (
      .clk       (clk),
      .rst_n     (rst_n),
      .arb_req   (mode_arb),
      .bus_bsy   (bus_ctl[CTL_BSY]),
      .bus_sel   (bus_ctl[CTL_SEL]),
      .bus_data  (bus_data),
      .arb_drive (arb_drive),
      .in_prog   (arb_in_prog),
      .lost      (arb_lost)
   );

   scsi_host_regs u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr        (host_addr),
      .wr          (host_wr),
      .rd          (host_rd),
      .wdata       (host_wdata),
      .rdata       (host_rdata),
      .bus_ctl     (bus_ctl),
      .bus_data    (bus_data),
      .bus_par     (bus_par),
      .phase_match (phase_match),
      .arb_in_prog (arb_in_prog),
      .arb_lost    (arb_lost),
      .dma_end     (dma_end_in),
      .dma_req     (dma_req_in),
      .par_err     (par_err_in),
      .irq         (irq_in),
      .busy_err    (busy_err_in),
      .last_byte   (last_byte_in),
      .out_byte    (out_byte),
      .line_cmd    (line_cmd),
      .phase_cmd   (phase_cmd),
      .mode_tgt    (mode_tgt),
      .mode_arb    (mode_arb),
      .sel_en      (sel_enable),
      .stb_send    (start_send),
      .stb_tgt_rx  (start_tgt_rx),
      .stb_ini_rx  (start_ini_rx),
      .stb_irq_clr (irq_clear)
   );

   assign line_hiz = line_cmd.hiz;

   always_comb begin
      scsi_ctl_assert  = '0;
      scsi_data_assert = '0;
      if (!line_hiz) begin
         scsi_ctl_assert[CTL_RST] = line_cmd.rst;
         scsi_ctl_assert[CTL_BSY] = line_cmd.bsy | arb_drive;
         scsi_ctl_assert[CTL_SEL] = line_cmd.sel;
         scsi_ctl_assert[CTL_ATN] = line_cmd.atn & ~mode_tgt;
         scsi_ctl_assert[CTL_ACK] = line_cmd.ack & ~mode_tgt;
         if (mode_tgt) begin
            scsi_ctl_assert[CTL_REQ] = phase_cmd[3];
            scsi_ctl_assert[CTL_MSG] = phase_cmd[2];
            scsi_ctl_assert[CTL_CD]  = phase_cmd[1];
            scsi_ctl_assert[CTL_IO]  = phase_cmd[0];
         end
         if (arb_drive) begin
            scsi_data_assert = out_byte | ID_BIT;
         end else if (line_cmd.dat && phase_match) begin
            scsi_data_assert = out_byte;
         end
      end
   end

endmodule

// File: rtl/scsi_bus_regs_chk.sv
module scsi_bus_regs_chk #(
   parameter int OWN_ID = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       mode_arb,
   input logic       mode_tgt,
   input logic       arb_in_prog,
   input logic       arb_lost,
   input logic       line_hiz,
   input logic [8:0] ctl_assert,
   input logic [7:0] data_assert,
   input logic       start_send,
   input logic       start_tgt_rx,
   input logic       start_ini_rx,
   input logic       irq_clear
);

   // R9: a won arbitration drives BSY and the own ID bit unless tri-stated
   a_r9_won_drives: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_in_prog && !line_hiz) |-> (ctl_assert[2] && data_assert[OWN_ID]));

   // R9: in-progress rises only after the arbitrate bit was set
   a_r9_rise_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(arb_in_prog) |-> $past(mode_arb));

   // R11: lost and in-progress never together, lost holds while requested
   a_r11_lost_excl: assert property (@(posedge clk) disable iff (!rst_n)
      arb_lost |-> !arb_in_prog);
   a_r11_lost_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (arb_lost && mode_arb) |=> arb_lost);

   // R12: dropping the request clears both flags one edge later
   a_r12_clear_flags: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_arb |=> (!arb_in_prog && !arb_lost));

   // R8: tri-state releases every line
   a_r8_hiz_release: assert property (@(posedge clk) disable iff (!rst_n)
      line_hiz |-> (ctl_assert == 9'd0 && data_assert == 8'd0));

   // R3: no ACK or ATN in target mode
   a_r3_tgt_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
      mode_tgt |-> (!ctl_assert[1] && !ctl_assert[0]));

   // R2: at most one strobe per cycle
   a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({start_send, start_tgt_rx, start_ini_rx, irq_clear}));

endmodule

bind scsi_bus_regs scsi_bus_regs_chk #(.OWN_ID(OWN_ID)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .mode_arb     (mode_arb),
   .mode_tgt     (mode_tgt),
   .arb_in_prog  (arb_in_prog),
   .arb_lost     (arb_lost),
   .line_hiz     (line_hiz),
   .ctl_assert   (scsi_ctl_assert),
   .data_assert  (scsi_data_assert),
   .start_send   (start_send),
   .start_tgt_rx (start_tgt_rx),
   .start_ini_rx (start_ini_rx),
   .irq_clear    (irq_clear)
);

// File: tb/sim_scsi_bus_regs.sv
module sim_scsi_bus_regs;

   localparam int OWN = 3;
   localparam int FREE = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] host_addr = '0;
   logic       host_wr = 1'b0;
   logic       host_rd = 1'b0;
   logic [7:0] host_wdata = '0;
   logic [7:0] host_rdata;
   logic [7:0] data_in;
   logic [8:0] ctl_in;
   logic [7:0] data_as;
   logic [8:0] ctl_as;
   logic [7:0] ext_data = '0;
   logic [8:0] ext_ctl = '0;
   logic       ext_par = 1'b0;
   logic       dma_end = 1'b0, dma_req = 1'b0, par_err = 1'b0, irq = 1'b0, busy_err = 1'b0;
   logic       last_byte = 1'b0;
   logic [7:0] sel_en;
   logic       st_send, st_trx, st_irx, irq_clr;

   int checks = 0;
   int fails = 0;

   always #10 clk = ~clk;

   assign ctl_in  = ctl_as | ext_ctl;
   assign data_in = data_as | ext_data;

   scsi_bus_regs #(.OWN_ID(OWN), .FREE_CYC(FREE), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wr(host_wr),
      .host_rd(host_rd), .host_wdata(host_wdata), .host_rdata(host_rdata),
      .scsi_data_in(data_in), .scsi_par_in(ext_par), .scsi_ctl_in(ctl_in),
      .scsi_data_assert(data_as), .scsi_ctl_assert(ctl_as),
      .dma_end_in(dma_end), .dma_req_in(dma_req), .par_err_in(par_err),
      .irq_in(irq), .busy_err_in(busy_err), .last_byte_in(last_byte),
      .sel_enable(sel_en), .start_send(st_send), .start_tgt_rx(st_trx),
      .start_ini_rx(st_irx), .irq_clear(irq_clr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      host_addr = a; host_wdata = d; host_wr = 1'b1;
      @(negedge clk);
      host_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      host_addr = a; host_rd = 1'b1;
      #1 d = host_rdata;
      host_rd = 1'b0;
      #1;
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      summary();
   end

   initial begin
      logic [7:0] r;
      logic [8:0] e;
      logic [7:0] ed;
      tick(4);
      rst_n = 1'b1;
      tick(1);

      // R1 reset state
      rd(3'd1, r); chk("R1 line reg", r, 0);
      rd(3'd2, r); chk("R1 mode reg", r, 0);
      rd(3'd3, r); chk("R1 phase reg", r, 0);
      chk("R1 ctl lines", ctl_as, 0);
      chk("R1 data lines", data_as, 0);
      chk("R1 sel enable", sel_en, 0);

      // R2 strobes and select enable
      host_addr = 3'd5; host_wdata = 8'h00; host_wr = 1'b1; #1;
      chk("R2 send strobe", {st_send, st_trx, st_irx, irq_clr}, 4'b1000);
      host_addr = 3'd6; #1;
      chk("R2 tgt rx strobe", {st_send, st_trx, st_irx, irq_clr}, 4'b0100);
      host_addr = 3'd7; #1;
      chk("R2 ini rx strobe", {st_send, st_trx, st_irx, irq_clr}, 4'b0010);
      @(negedge clk); host_wr = 1'b0;
      host_addr = 3'd7; host_rd = 1'b1; #1;
      chk("R2 irq clear strobe", {st_send, st_trx, st_irx, irq_clr}, 4'b0001);
      chk("R2 addr7 read", host_rdata, 0);
      host_rd = 1'b0; #1;
      chk("R2 no strobe idle", {st_send, st_trx, st_irx, irq_clr}, 4'b0000);
      tick(1);
      wr(3'd4, 8'h96); chk("R2 sel enable", sel_en, 8'h96);

      // R3/R4/R8 line command sweep, initiator mode, phase 000
      wr(3'd0, 8'hA5);
      tick(3);
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = 8'(v);
         wr(3'd1, b);
         e = '0;
         if (!b[6]) begin
            e[4] = b[7]; e[1] = b[4]; e[2] = b[3]; e[3] = b[2]; e[0] = b[1];
         end
         chk(b[6] ? "R8 hiz ctl" : "R3 ctl map", ctl_as, e);
         chk(b[6] ? "R8 hiz data" : "R4 data drive", data_as,
             (!b[6] && b[0]) ? 8'hA5 : 8'h00);
         rd(3'd1, r);
         chk("R3 line readback", r, {b[7], 2'b00, b[4:0]});
      end

      // R3/R5 target mode sweep
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h40);
      for (int v = 0; v < 256; v++) begin
         logic [7:0] b;
         b = 8'(v);
         wr(3'd1, b);
         e = '0;
         if (!b[6]) begin
            e[4] = b[7]; e[2] = b[3]; e[3] = b[2];
         end
         chk("R3 target ctl", ctl_as, e);
      end
      wr(3'd1, 8'h00);
      for (int t = 0; t < 16; t++) begin
         wr(3'd3, 8'(t));
         e = '0;
         e[8] = t[3]; e[7] = t[2]; e[6] = t[1]; e[5] = t[0];
         chk("R5 target phase lines", ctl_as, e);
         last_byte = t[0]; #1;
         rd(3'd3, r);
         chk("R5 phase readback", r, {t[0], 3'b000, 4'(t)});
      end
      wr(3'd3, 8'h00);
      wr(3'd2, 8'h00);
      last_byte = 1'b0;

      // R4/R7 phase crossing in initiator mode
      wr(3'd0, 8'h5A);
      wr(3'd1, 8'h01);
      for (int p = 0; p < 8; p++) begin
         ext_ctl[7] = p[2]; ext_ctl[6] = p[1]; ext_ctl[5] = p[0];
         tick(3);
         for (int t = 0; t < 16; t++) begin
            wr(3'd3, 8'(t));
            chk("R4 phase gated data", data_as, (t[2:0] == p[2:0]) ? 8'h5A : 8'h00);
            chk("R5 no REQ in initiator", ctl_as[8], 0);
            rd(3'd5, r);
            chk("R7 phase match bit", r, {4'b0000, (t[2:0] == p[2:0]), 3'b000});
         end
      end
      ext_ctl = '0;
      wr(3'd1, 8'h00);
      wr(3'd3, 8'h00);
      wr(3'd0, 8'h00);
      tick(3);

      // R6 status sweep and latency
      for (int i = 0; i < 256; i++) begin
         logic [7:0] s;
         s = 8'(i);
         ext_ctl = '0;
         ext_ctl[4] = s[7]; ext_ctl[2] = s[6]; ext_ctl[8] = s[5]; ext_ctl[7] = s[4];
         ext_ctl[6] = s[3]; ext_ctl[5] = s[2]; ext_ctl[3] = s[1]; ext_par = s[0];
         tick(2);
         rd(3'd4, r);
         chk("R6 status bits", r, s);
      end
      ext_ctl = '0; ext_par = 1'b0;
      tick(3);
      ext_ctl[2] = 1'b1;
      tick(1); rd(3'd4, r); chk("R6 latency one edge", r, 8'h00);
      tick(1); rd(3'd4, r); chk("R6 latency two edges", r, 8'h40);
      ext_ctl = '0;
      ext_data = 8'hC3; tick(2); rd(3'd0, r); chk("R6 current data", r, 8'hC3);
      ext_data = 8'h00;

      // R7 transfer flag sweep
      for (int i = 0; i < 32; i++) begin
         {dma_end, dma_req, par_err, irq, busy_err} = 5'(i);
         ext_ctl[0] = i[0]; ext_ctl[1] = i[1];
         tick(2);
         rd(3'd5, r);
         ed = {i[4], i[3], i[2], i[1], 1'b0, i[0], i[0], i[1]};
         // phase 000 matches phase command 000
         ed[3] = 1'b1;
         chk("R7 bus status bits", r, ed);
      end
      {dma_end, dma_req, par_err, irq, busy_err} = '0;
      ext_ctl = '0;
      tick(3);

      // R13 input latch
      ext_data = 8'h3C; ext_ctl[8] = 1'b1; tick(4);
      ext_ctl[8] = 1'b0; tick(4);
      ext_data = 8'h77; tick(4);
      rd(3'd6, r); chk("R13 latch on REQ fall", r, 8'h3C);
      ext_ctl[1] = 1'b1; tick(4); ext_ctl[1] = 1'b0; tick(4);
      rd(3'd6, r); chk("R13 ACK ignored in initiator", r, 8'h3C);
      wr(3'd2, 8'h40);
      ext_ctl[1] = 1'b1; tick(4); ext_ctl[1] = 1'b0; tick(4);
      rd(3'd6, r); chk("R13 latch on ACK fall target", r, 8'h77);
      wr(3'd2, 8'h00);
      ext_data = 8'h00; ext_ctl = '0;
      tick(4);

      // R9 mode readback
      for (int m = 0; m < 256; m += 17) begin
         logic [7:0] mv;
         mv = 8'(m) & 8'hFE;
         wr(3'd2, mv); rd(3'd2, r); chk("R9 mode readback", r, mv);
      end
      wr(3'd2, 8'h00);
      tick(3);

      // R9 arbitration on a free bus, exact window
      wr(3'd2, 8'h01);
      tick(FREE);
      rd(3'd1, r); chk("R9 no win before window", r[6], 0);
      tick(2);
      rd(3'd1, r); chk("R9 in progress", r[7:5], 3'b010);
      chk("R9 BSY driven", ctl_as[2], 1);
      chk("R9 own id driven", data_as, 8'h08);

      // R11 lower id contender has no effect
      ext_ctl[3] = 1'b1; ext_data = 8'h02; tick(4);
      rd(3'd1, r); chk("R11 lower id keeps win", r[6:5], 2'b10);
      // R11 higher id contender
      ext_data = 8'h20; tick(4);
      rd(3'd1, r); chk("R11 lost flags", r[6:5], 2'b01);
      chk("R11 BSY released", ctl_as[2], 0);
      chk("R11 data released", data_as, 0);

      // R12 clearing the request
      wr(3'd2, 8'h00); tick(1);
      rd(3'd1, r); chk("R12 flags cleared", r[6:5], 2'b00);
      ext_ctl = '0; ext_data = '0;
      tick(4);

      // R10 busy bus holds off arbitration
      ext_ctl[2] = 1'b1; tick(3);
      wr(3'd2, 8'h01);
      tick(3 * FREE);
      rd(3'd1, r); chk("R10 no win while busy", r[6], 0);
      chk("R10 no BSY drive", ctl_as[2], 0);
      ext_ctl[2] = 1'b0;
      tick(FREE + 1);
      rd(3'd1, r); chk("R10 still counting", r[6], 0);
      tick(4);
      rd(3'd1, r); chk("R10 win after release", r[6], 1);

      // R8 tri-state overrides arbitration drive
      wr(3'd1, 8'h40);
      chk("R8 hiz over arbitration ctl", ctl_as, 0);
      chk("R8 hiz over arbitration data", data_as, 0);
      wr(3'd1, 8'h00);
      wr(3'd2, 8'h00);
      tick(2);

      summary();
   end

endmodule